// File: doc/BRIEF.md
# Logic Self-Test Wrapper with Pattern Generator and Signature Compactor

This block sits around a purely combinational logic block and gives it two personalities. In functional mode the wrapper adds nothing: functional input data reaches the logic block's inputs unchanged, and the block's response returns to the functional output in the same cycle. In self-test mode the input side becomes a pseudo-random vector source, and the output side becomes a signature compactor that folds every response into a running value.

A run begins with a start pulse while self-test mode is selected. The source is reloaded with a fixed non-zero seed and the signature is cleared. For a fixed number of clocks, one new vector is applied and one response is folded on each clock. On the clock that folds the last response, the finished signature is compared with a known-good value presented on an input port. The completion flag and the verdict flag then stay steady until the next start or until functional mode is selected. The known-good value is worked out offline from the same generator, compactor and logic.

Top module: `lbist_wrapper`

## Requirements
- R1: While `testMode` is 0, `cutIn` equals `funcIn` and `funcOut` equals `cutOut` combinationally, with no register in either path.
- R2: While `testMode` is 1, `cutIn` carries the generator state and `funcOut` is driven to 0. The generator shifts left on each run clock. The new bit 0 is the XOR of bits 7, 5, 4 and 3, for the 8-bit default width and a maximal-length sequence. The state is never zero.
- R3: On the edge that accepts a start, the generator loads the seed (default 8'h01) and the signature clears to 0. On every run clock, the signature becomes its left-shifted self, with bit 0 set to the XOR of bits 7, 5, 4 and 3, and the whole word then XORed with `cutOut`.
- R4: On the edge that folds the last response, `pass` becomes 1 exactly when the new signature equals `expectSig`.
- R5: A run folds exactly NUM_PATTERNS responses (default 200). `done` rises on the edge of the last fold. `done`, `pass` and `signature` then hold while `testMode` stays 1 and `start` stays low.
- R6: A start pulse is ignored while a run is in progress, and also while `testMode` is 0.
- R7: Any edge that samples `testMode` at 0 stops a run in progress and clears `done` and `pass`. The signature keeps the value it had at the abort.
- R8: After reset `done` and `pass` are 0, `signature` is 0 and the generator holds the seed.
- R9: A start accepted while `done` is 1 clears both flags and begins a complete new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testMode | input | 1 | 1 selects self-test, 0 selects functional pass-through |
| start | input | 1 | Single-cycle request to begin a self-test run |
| expectSig | input | OUT_W | Known-good signature for the final compare |
| funcIn | input | IN_W | Functional data toward the logic under test |
| cutIn | output | IN_W | Drive to the inputs of the logic under test |
| cutOut | input | OUT_W | Response from the logic under test |
| funcOut | output | OUT_W | Functional result toward the rest of the chip |
| signature | output | OUT_W | Current compactor contents |
| done | output | 1 | Run completed |
| pass | output | 1 | Final signature matched the known-good value |

## Verification
The verdict assertion assumes that `expectSig` is held steady across the edge that completes a run. The bench therefore sets the known-good value before each start and leaves it unchanged until after completion. The assertions also assume that `cutOut` is a function of `cutIn` alone. The bench models the logic under test as a fixed combinational mix of the vector, so each response in a run is repeatable. Start pulses in the middle of a run, and a drop of the mode input in the middle of a run, are applied only at defined points between edges. This lets the reference model, updated once per clock, predict which run and which flags each edge produces.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bistState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic seedLoad;  // reload generator, clear signature
    logic advance;   // apply next vector, fold one response
  } bistStrobe_t;

  // Feedback tap mask for a left-shifting shift register of the given width.
  function automatic logic [31:0] fbMask(input int unsigned width);
    case (width)
      4:       fbMask = 32'h0000_000C;
      5:       fbMask = 32'h0000_0014;
      6:       fbMask = 32'h0000_0030;
      7:       fbMask = 32'h0000_0060;
      8:       fbMask = 32'h0000_00B8;
      12:      fbMask = 32'h0000_0E08;
      16:      fbMask = 32'h0000_B400;
      24:      fbMask = 32'h00E1_0000;
      32:      fbMask = 32'h8020_0003;
      default: fbMask = 32'h0000_0003 << (width - 2);
    endcase
  endfunction

endpackage

// File: rtl/lbist_lfsr.sv
module lbist_lfsr #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         seedLoad,
  input  logic         advance,
  output logic [W-1:0] state
);
  import lbist_pkg::*;

  localparam logic [31:0]  MASK_FULL = fbMask(W);
  localparam logic [W-1:0] MASK      = MASK_FULL[W-1:0];

  logic         feedBit;
  logic [W-1:0] stateNext;

  assign feedBit   = ^(state & MASK);
  assign stateNext = {state[W-2:0], feedBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         state <= SEED;
    else if (seedLoad) state <= SEED;
    else if (advance)  state <= stateNext;
  end

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         advance,
  input  logic [W-1:0] respIn,
  output logic [W-1:0] sig,
  output logic [W-1:0] sigNext
);
  import lbist_pkg::*;

  localparam logic [31:0]  MASK_FULL = fbMask(W);
  localparam logic [W-1:0] MASK      = MASK_FULL[W-1:0];

  logic feedBit;

  assign feedBit = ^(sig & MASK);
  assign sigNext = {sig[W-2:0], feedBit} ^ respIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        sig <= '0;
    else if (clear)   sig <= '0;
    else if (advance) sig <= sigNext;
  end

endmodule

// File: rtl/lbist_datapath.sv
module lbist_datapath
  import lbist_pkg::*;
#(
  parameter int unsigned  IN_W  = 8,
  parameter int unsigned  OUT_W = 8,
  parameter logic [IN_W-1:0] SEED = IN_W'(1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testMode,
  input  bistStrobe_t      strobe,
  input  logic [IN_W-1:0]  funcIn,
  input  logic [OUT_W-1:0] cutOut,
  input  logic [OUT_W-1:0] expectSig,
  output logic [IN_W-1:0]  cutIn,
  output logic [OUT_W-1:0] funcOut,
  output logic [OUT_W-1:0] signature,
  output logic             sigMatchNext
);

  logic [IN_W-1:0]  patState;
  logic [OUT_W-1:0] sigNext;

  lbist_lfsr #(.W(IN_W), .SEED(SEED)) genU (
    .clk      (clk),
    .rstN     (rstN),
    .seedLoad (strobe.seedLoad),
    .advance  (strobe.advance),
    .state    (patState)
  );

  lbist_misr #(.W(OUT_W)) cmpU (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobe.seedLoad),
    .advance (strobe.advance),
    .respIn  (cutOut),
    .sig     (signature),
    .sigNext (sigNext)
  );

  // wrapper muxes: transparent in functional mode
  assign cutIn        = testMode ? patState : funcIn;
  assign funcOut      = testMode ? '0 : cutOut;
  assign sigMatchNext = (sigNext == expectSig);

endmodule

// File: rtl/lbist_control.sv
module lbist_control
  import lbist_pkg::*;
#(
  parameter int unsigned NUM_PATTERNS = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        testMode,
  input  logic        start,
  input  logic        sigMatchNext,
  output bistStrobe_t strobe,
  output logic        done,
  output logic        pass
);

  localparam int unsigned CNT_W = (NUM_PATTERNS > 1) ? $clog2(NUM_PATTERNS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_PATTERNS - 1);

  bistState_e      state;
  logic [CNT_W-1:0] patCnt;
  logic            lastFold;

  assign strobe.seedLoad = testMode && start && (state != ST_RUN);
  assign strobe.advance  = testMode && (state == ST_RUN);
  assign lastFold        = strobe.advance && (patCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      patCnt <= '0;
      done   <= 1'b0;
      pass   <= 1'b0;
    end else if (!testMode) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else if (strobe.seedLoad) begin
      state  <= ST_RUN;
      patCnt <= '0;
      done   <= 1'b0;
      pass   <= 1'b0;
    end else if (lastFold) begin
      state <= ST_DONE;
      done  <= 1'b1;
      pass  <= sigMatchNext;
    end else if (strobe.advance) begin
      patCnt <= patCnt + 1'b1;
    end
  end

endmodule

// File: rtl/lbist_wrapper.sv
module lbist_wrapper
  import lbist_pkg::*;
#(
  parameter int unsigned     IN_W         = 8,
  parameter int unsigned     OUT_W        = 8,
  parameter int unsigned     NUM_PATTERNS = 200,
  parameter logic [IN_W-1:0] SEED         = IN_W'(1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testMode,
  input  logic             start,
  input  logic [OUT_W-1:0] expectSig,
  input  logic [IN_W-1:0]  funcIn,
  output logic [IN_W-1:0]  cutIn,
  input  logic [OUT_W-1:0] cutOut,
  output logic [OUT_W-1:0] funcOut,
  output logic [OUT_W-1:0] signature,
  output logic             done,
  output logic             pass
);

  bistStrobe_t strobe;
  logic        sigMatchNext;

  lbist_control #(.NUM_PATTERNS(NUM_PATTERNS)) ctrlU (
    .clk          (clk),
    .rstN         (rstN),
    .testMode     (testMode),
    .start        (start),
    .sigMatchNext (sigMatchNext),
    .strobe       (strobe),
    .done         (done),
    .pass         (pass)
  );

  lbist_datapath #(.IN_W(IN_W), .OUT_W(OUT_W), .SEED(SEED)) dpU (
    .clk          (clk),
    .rstN         (rstN),
    .testMode     (testMode),
    .strobe       (strobe),
    .funcIn       (funcIn),
    .cutOut       (cutOut),
    .expectSig    (expectSig),
    .cutIn        (cutIn),
    .funcOut      (funcOut),
    .signature    (signature),
    .sigMatchNext (sigMatchNext)
  );

endmodule

// File: rtl/lbist_wrapper_sva.sv
module lbist_wrapper_sva #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             testMode,
  input logic             start,
  input logic [OUT_W-1:0] expectSig,
  input logic [IN_W-1:0]  funcIn,
  input logic [IN_W-1:0]  cutIn,
  input logic [OUT_W-1:0] cutOut,
  input logic [OUT_W-1:0] funcOut,
  input logic [OUT_W-1:0] signature,
  input logic             done,
  input logic             pass
);

  a_r1_transparent: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> (cutIn == funcIn && funcOut == cutOut));

  a_r2_gen_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> (cutIn != '0 && funcOut == '0));

  a_r4_verdict: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (pass == (signature == expectSig)));

  a_r4_pass_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && testMode && !start) |=> (done && $stable(pass) && $stable(signature)));

  a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |=> (!done && !pass));

endmodule

bind lbist_wrapper lbist_wrapper_sva #(.IN_W(IN_W), .OUT_W(OUT_W)) svaU (.*);

// File: tb/lbist_wrapper_tb_top.sv
`timescale 1ns/1ps
module lbist_wrapper_tb_top;

  localparam int NPAT = 200;
  localparam logic [7:0] SEEDV = 8'h01;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testMode = 1'b0;
  logic start = 1'b0;
  logic [7:0] expectSig = 8'h00;
  logic [7:0] funcIn = 8'h00;
  logic [7:0] cutIn, cutOut, funcOut, signature;
  logic done, pass;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic [7:0] mGen = SEEDV;
  logic [7:0] mSig = 8'h00;
  int mCnt = 0;
  bit mRun = 0, mDone = 0, mPass = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] cutFn(input logic [7:0] x);
    return {x[3:0], x[7:4]} ^ (x << 1) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] shiftFb(input logic [7:0] x);
    return {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
  endfunction

  assign cutOut = cutFn(cutIn);

  lbist_wrapper #(.IN_W(8), .OUT_W(8), .NUM_PATTERNS(NPAT), .SEED(SEEDV)) dut_i (
    .clk(clk), .rstN(rstN), .testMode(testMode), .start(start),
    .expectSig(expectSig), .funcIn(funcIn), .cutIn(cutIn), .cutOut(cutOut),
    .funcOut(funcOut), .signature(signature), .done(done), .pass(pass));

  function automatic logic [7:0] goldSig();
    logic [7:0] g = SEEDV;
    logic [7:0] s = 8'h00;
    for (int i = 0; i < NPAT; i++) begin
      s = shiftFb(s) ^ cutFn(g);
      g = shiftFb(g);
    end
    return s;
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk(testMode ? "R2" : "R1", "cutIn", cutIn, testMode ? mGen : funcIn);
    chk(testMode ? "R2" : "R1", "funcOut", funcOut, testMode ? 8'h00 : cutFn(funcIn));
    chk("R3", "signature", signature, mSig);
    chk("R5", "done", {7'd0, done}, {7'd0, mDone});
    chk("R4", "pass", {7'd0, pass}, {7'd0, mPass});
  endtask

  // drive inputs for the coming edge, advance the model, compare after the edge
  task automatic tick(input bit st, input bit md, input logic [7:0] fi);
    start = st; testMode = md; funcIn = fi;
    if (!md) begin
      mRun = 0; mDone = 0; mPass = 0;
    end else if (st && !mRun) begin
      mGen = SEEDV; mSig = 8'h00; mCnt = 0; mRun = 1; mDone = 0; mPass = 0;
    end else if (mRun) begin
      mSig = shiftFb(mSig) ^ cutFn(mGen);
      mGen = shiftFb(mGen);
      if (mCnt == NPAT - 1) begin
        mRun = 0; mDone = 1; mPass = (mSig == expectSig);
      end else mCnt++;
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [7:0] gold;
    gold = goldSig();
    // R8: reset state, generator seed visible in test mode
    testMode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "cutIn seed", cutIn, SEEDV);
    chk("R8", "signature", signature, 8'h00);
    chk("R8", "done", {7'd0, done}, 8'h00);
    chk("R8", "pass", {7'd0, pass}, 8'h00);
    rstN = 1'b1;
    // R1: functional pass-through with varied data
    for (int i = 0; i < 20; i++) tick(0, 0, 8'(i * 37 + 11));
    tick(0, 0, 8'hFF);
    tick(0, 0, 8'h00);
    // R6: start in functional mode is ignored
    tick(1, 0, 8'hA5);
    tick(0, 0, 8'h5A);
    chk("R6", "no run after start in functional mode", {7'd0, done}, 8'h00);
    // full passing run, with stray starts mid-run (R6)
    expectSig = gold;
    tick(0, 1, 8'h00);
    tick(1, 1, 8'h00);
    for (int i = 0; i < NPAT + 5; i++) tick((i == 50 || i == 120), 1, 8'h33);
    chk("R4", "pass after good run", {7'd0, pass}, 8'h01);
    chk("R3", "final signature", signature, gold);
    // R9: restart from done with a wrong known-good value
    expectSig = gold ^ 8'h01;
    tick(1, 1, 8'h00);
    chk("R9", "done cleared on restart", {7'd0, done}, 8'h00);
    for (int i = 0; i < NPAT + 3; i++) tick(0, 1, 8'h00);
    chk("R4", "fail verdict", {7'd0, pass}, 8'h00);
    chk("R5", "done after mismatch run", {7'd0, done}, 8'h01);
    // R7: abort in the middle of a run
    expectSig = gold;
    tick(1, 1, 8'h00);
    for (int i = 0; i < 40; i++) tick(0, 1, 8'h00);
    tick(0, 0, 8'h77);
    chk("R7", "done after abort", {7'd0, done}, 8'h00);
    for (int i = 0; i < 5; i++) tick(0, 0, 8'(i));
    // re-enter test mode: no run without a start
    for (int i = 0; i < 10; i++) tick(0, 1, 8'h00);
    // complete run after abort passes again
    tick(1, 1, 8'h00);
    for (int i = 0; i < NPAT + 2; i++) tick(0, 1, 8'h00);
    chk("R4", "pass after re-run", {7'd0, pass}, 8'h01);
    // abort from done
    tick(0, 0, 8'h10);
    chk("R7", "pass cleared from done", {7'd0, pass}, 8'h00);
    finish();
  end

endmodule